// File: doc/BRIEF.md
# Two-Way Lockable Line Cache Controller

This block is a two-way set-associative data cache placed between a core load/store port and a slower memory port. Lines hold 64 bytes. The core reads and writes 64-bit words. The number of sets comes from a size parameter. Each set keeps one least-recently-used bit, and each line keeps a valid bit and a dirty bit. A policy pin chooses the write policy for each access. With the pin low, writes are write-back with allocate. With the pin high, writes are write-through and a write miss does not allocate. Read misses always allocate when a line can be replaced.

Each way can be locked through a pin. A valid line in a locked way is never replaced, but an invalid line in a locked way can still take a fill. When the set has no line that can be replaced, the miss becomes a single-word pass-through access to memory and the cache is not changed. While the controller writes back a dirty victim, fills a line or runs a single-word access, it holds the core stalled. Miss handling runs to its end once it has started.

The memory side has three valid/ready streams: a command stream, a write-data stream and a read-data stream. A payload moves only on a cycle where valid and ready are both high. The controller holds valid and its payload unchanged until ready is seen, and it accepts read data whenever it is waiting for a beat. A line moves as 8 beats of 64 bits, lowest word first.

Top module: `cache2w_ctrl`

## Requirements
- R1: After reset every line is invalid. With no request, core_stall is low and no memory command is raised. The first access to any address misses.
- R2: The address is split into a byte field [2:0], which is ignored, a word field [5:3], an index field of IDX_W bits starting at bit 6 (bits [9:6] at the default size), and a tag made of the remaining upper bits.
- R3: A read that hits completes in the cycle it is presented: core_stall stays low and core_rdata returns the stored word.
- R4: A read miss raises core_stall and issues one read command with mem_cmd_line=1 at the line-aligned address. It then takes 8 beats into the chosen way, and the access completes as a hit.
- R5: With wt_mode low, a write hit updates the line, marks it dirty, completes with no stall and causes no memory traffic.
- R6: A dirty victim is written back as one line write command plus 8 beats. This happens before the fill command for the new line, so memory then holds the modified data.
- R7: With wt_mode high, every write goes to memory as a single-beat write (mem_cmd_line=0) at the word address. A hit also updates the cached word. A miss allocates no line, so a later read of that address misses.
- R8: When both ways of a set are valid and unlocked, a miss replaces the least recently used way. A hit or a fill makes its way the most recently used.
- R9: On a miss, an invalid way is filled before any valid way is replaced, way 0 before way 1. This applies even when that way is locked.
- R10: A valid line in a way whose lock_way bit is 1 is never replaced.
- R11: When both ways of the set are valid and locked, a miss becomes a single-beat memory read or write (mem_cmd_line=0). No line fill takes place and the cached lines are unchanged.
- R12: Each memory stream holds valid and its payload stable until ready. Write beats follow only a write command and match its length (8 beats or 1 beat). Random back-pressure leaves read data correct.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wt_mode | input | 1 | 1: write-through without allocate, 0: write-back with allocate |
| lock_way | input | 2 | Per-way lock, bit w locks way w |
| core_req | input | 1 | Core access request, held until core_stall is low |
| core_we | input | 1 | 1 = write, 0 = read |
| core_addr | input | ADDR_W | Byte address |
| core_wdata | input | DATA_W | Write word |
| core_rdata | output | DATA_W | Read word, valid when core_req is high and core_stall is low |
| core_stall | output | 1 | Access not yet complete |
| mem_cmd_valid | output | 1 | Command valid |
| mem_cmd_ready | input | 1 | Command ready |
| mem_cmd_write | output | 1 | 1 = write command |
| mem_cmd_line | output | 1 | 1 = 8-beat line, 0 = single beat |
| mem_cmd_addr | output | ADDR_W | Command byte address |
| mem_wr_valid | output | 1 | Write beat valid |
| mem_wr_ready | input | 1 | Write beat ready |
| mem_wr_data | output | DATA_W | Write beat data |
| mem_rd_valid | input | 1 | Read beat valid |
| mem_rd_ready | output | 1 | Read beat ready |
| mem_rd_data | input | DATA_W | Read beat data |

## Verification
The assertions assume that the core holds its request, address, write data and wt_mode steady while core_stall is high. They also assume lock_way changes only between accesses, and that memory sends read beats only for a command it has accepted. The stimulus drives each access from one task. That task holds every core input until the stall clears and drops the request just after the completing edge. Lock and policy changes are made only while no request is raised. The memory model answers only commands it has taken, with the matching number of beats, under optional random back-pressure.

// File: rtl/cache2w_pkg.sv
package cache2w_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_WB_CMD,
    ST_WB_DAT,
    ST_FL_CMD,
    ST_FL_DAT,
    ST_PT_CMD,
    ST_PT_WR,
    ST_PT_RD,
    ST_DONE
  } ctl_state_e;
endpackage

// File: rtl/cache2w_tagstore.sv
module cache2w_tagstore #(
  parameter int IDX_W = 4,
  parameter int TAG_W = 22
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [IDX_W-1:0]       rd_idx,
  output logic [1:0]             way_valid,
  output logic [1:0]             way_dirty,
  output logic [1:0][TAG_W-1:0]  way_tag,
  output logic                   lru_way,
  input  logic                   fill_en,
  input  logic                   fill_way,
  input  logic [IDX_W-1:0]       fill_idx,
  input  logic [TAG_W-1:0]       fill_tag,
  input  logic                   dirty_en,
  input  logic                   dirty_way,
  input  logic [IDX_W-1:0]       dirty_idx,
  input  logic                   lru_en,
  input  logic                   lru_used_way,
  input  logic [IDX_W-1:0]       lru_idx
);
  localparam int SETS = 1 << IDX_W;

  logic [SETS-1:0] lru_q;

  for (genvar w = 0; w < 2; w++) begin : g_way
    logic [SETS-1:0]  vld_q;
    logic [SETS-1:0]  drt_q;
    logic [TAG_W-1:0] tag_q [SETS];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q <= '0;
        drt_q <= '0;
      end else if (fill_en && fill_way == 1'(w)) begin
        vld_q[fill_idx] <= 1'b1;
        drt_q[fill_idx] <= 1'b0;
      end else if (dirty_en && dirty_way == 1'(w)) begin
        drt_q[dirty_idx] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (fill_en && fill_way == 1'(w)) tag_q[fill_idx] <= fill_tag;
    end

    assign way_valid[w] = vld_q[rd_idx];
    assign way_dirty[w] = drt_q[rd_idx];
    assign way_tag[w]   = tag_q[rd_idx];
  end

  // the stored bit names the way to replace next
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lru_q <= '0;
    else if (lru_en) lru_q[lru_idx] <= ~lru_used_way;
  end

  assign lru_way = lru_q[rd_idx];
endmodule

// File: rtl/cache2w_dataram.sv
module cache2w_dataram #(
  parameter int IDX_W  = 4,
  parameter int BEAT_W = 3,
  parameter int DATA_W = 64
) (
  input  logic                   clk,
  input  logic [IDX_W-1:0]       rd_idx,
  input  logic [BEAT_W-1:0]      rd_beat,
  output logic [1:0][DATA_W-1:0] rd_data,
  input  logic                   wr_en,
  input  logic                   wr_way,
  input  logic [IDX_W-1:0]       wr_idx,
  input  logic [BEAT_W-1:0]      wr_beat,
  input  logic [DATA_W-1:0]      wr_data
);
  localparam int WORDS = 1 << (IDX_W + BEAT_W);

  for (genvar w = 0; w < 2; w++) begin : g_way
    logic [DATA_W-1:0] mem_q [WORDS];

    always_ff @(posedge clk) begin
      if (wr_en && wr_way == 1'(w)) mem_q[{wr_idx, wr_beat}] <= wr_data;
    end

    assign rd_data[w] = mem_q[{rd_idx, rd_beat}];
  end
endmodule

// File: rtl/cache2w_victim.sv
module cache2w_victim (
  input  logic [1:0] way_valid,
  input  logic [1:0] lock_way,
  input  logic       lru_way,
  output logic       can_alloc,
  output logic       pick_way
);
  always_comb begin
    can_alloc = 1'b1;
    pick_way  = 1'b0;
    if (!way_valid[0])                     pick_way = 1'b0;
    else if (!way_valid[1])                pick_way = 1'b1;
    else if (!lock_way[0] && !lock_way[1]) pick_way = lru_way;
    else if (!lock_way[0])                 pick_way = 1'b0;
    else if (!lock_way[1])                 pick_way = 1'b1;
    else                                   can_alloc = 1'b0;
  end
endmodule

// File: rtl/cache2w_ctrl.sv
module cache2w_ctrl
  import cache2w_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 64,
  parameter int SIZE_KB = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wt_mode,
  input  logic [1:0]        lock_way,
  input  logic              core_req,
  input  logic              core_we,
  input  logic [ADDR_W-1:0] core_addr,
  input  logic [DATA_W-1:0] core_wdata,
  output logic [DATA_W-1:0] core_rdata,
  output logic              core_stall,
  output logic              mem_cmd_valid,
  input  logic              mem_cmd_ready,
  output logic              mem_cmd_write,
  output logic              mem_cmd_line,
  output logic [ADDR_W-1:0] mem_cmd_addr,
  output logic              mem_wr_valid,
  input  logic              mem_wr_ready,
  output logic [DATA_W-1:0] mem_wr_data,
  input  logic              mem_rd_valid,
  output logic              mem_rd_ready,
  input  logic [DATA_W-1:0] mem_rd_data
);
  localparam int LINE_BYTES = 64;
  localparam int BYTE_W     = $clog2(DATA_W / 8);
  localparam int OFS_W      = $clog2(LINE_BYTES);
  localparam int BEAT_W     = OFS_W - BYTE_W;
  localparam int NBEATS     = 1 << BEAT_W;
  localparam int SETS       = (SIZE_KB * 1024) / (LINE_BYTES * 2);
  localparam int IDX_W      = $clog2(SETS);
  localparam int TAG_W      = ADDR_W - IDX_W - OFS_W;
  localparam int WA_W       = ADDR_W - BYTE_W;

  ctl_state_e          state_q;
  logic [WA_W-1:0]     lat_wa_q;
  logic                lat_we_q;
  logic [DATA_W-1:0]   lat_wdata_q;
  logic                vway_q;
  logic [BEAT_W-1:0]   cnt_q;
  logic [DATA_W-1:0]   byp_q;

  wire unused_byte_sel = ^core_addr[BYTE_W-1:0];

  logic                idle;
  logic [WA_W-1:0]     cur_wa;
  logic [BEAT_W-1:0]   c_beat;
  logic [IDX_W-1:0]    c_idx;
  logic [TAG_W-1:0]    c_tag;

  assign idle   = (state_q == ST_IDLE);
  assign cur_wa = idle ? core_addr[ADDR_W-1:BYTE_W] : lat_wa_q;
  assign c_beat = cur_wa[BEAT_W-1:0];
  assign c_idx  = cur_wa[BEAT_W +: IDX_W];
  assign c_tag  = cur_wa[WA_W-1 -: TAG_W];

  // tag store
  logic [1:0]             way_valid, way_dirty;
  logic [1:0][TAG_W-1:0]  way_tag;
  logic                   lru_way;
  logic                   tag_fill_en, dirty_en, lru_en, lru_used_way;

  cache2w_tagstore #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst_n(rst_n), .rd_idx(c_idx),
    .way_valid(way_valid), .way_dirty(way_dirty), .way_tag(way_tag), .lru_way(lru_way),
    .fill_en(tag_fill_en), .fill_way(vway_q), .fill_idx(c_idx), .fill_tag(c_tag),
    .dirty_en(dirty_en), .dirty_way(lru_used_way), .dirty_idx(c_idx),
    .lru_en(lru_en), .lru_used_way(lru_used_way), .lru_idx(c_idx)
  );

  // hit detection
  logic [1:0] hit_w;
  logic       hit_any, hit_way;
  for (genvar w = 0; w < 2; w++) begin : g_hit
    assign hit_w[w] = way_valid[w] && (way_tag[w] == c_tag);
  end
  assign hit_any = |hit_w;
  assign hit_way = hit_w[1];

  // victim choice
  logic can_alloc, pick_way;
  cache2w_victim u_vic (
    .way_valid(way_valid), .lock_way(lock_way), .lru_way(lru_way),
    .can_alloc(can_alloc), .pick_way(pick_way)
  );

  // data array
  logic [1:0][DATA_W-1:0] ram_rd;
  logic                   ram_we, ram_way;
  logic [BEAT_W-1:0]      ram_rbeat;
  logic [DATA_W-1:0]      ram_wdata;

  assign ram_rbeat = (state_q == ST_WB_DAT) ? cnt_q : c_beat;

  cache2w_dataram #(.IDX_W(IDX_W), .BEAT_W(BEAT_W), .DATA_W(DATA_W)) u_ram (
    .clk(clk), .rd_idx(c_idx), .rd_beat(ram_rbeat), .rd_data(ram_rd),
    .wr_en(ram_we), .wr_way(ram_way), .wr_idx(c_idx),
    .wr_beat(idle ? c_beat : cnt_q), .wr_data(ram_wdata)
  );

  logic idle_hit, cmd_fire, wr_fire, rd_fire, last_beat, wt_write;
  assign idle_hit  = idle && core_req && hit_any;
  assign wt_write  = core_we && wt_mode;
  assign cmd_fire  = mem_cmd_valid && mem_cmd_ready;
  assign wr_fire   = mem_wr_valid && mem_wr_ready;
  assign rd_fire   = mem_rd_valid && mem_rd_ready;
  assign last_beat = (cnt_q == BEAT_W'(NBEATS - 1));

  // array and state-bit updates
  always_comb begin
    ram_we       = 1'b0;
    ram_way      = vway_q;
    ram_wdata    = mem_rd_data;
    dirty_en     = 1'b0;
    lru_en       = 1'b0;
    lru_used_way = vway_q;
    tag_fill_en  = 1'b0;
    if (idle_hit) begin
      lru_en       = 1'b1;
      lru_used_way = hit_way;
      if (core_we) begin
        ram_we    = 1'b1;
        ram_way   = hit_way;
        ram_wdata = core_wdata;
        dirty_en  = !wt_mode;
      end
    end else if (state_q == ST_FL_DAT && rd_fire) begin
      ram_we = 1'b1;
      if (last_beat) begin
        tag_fill_en = 1'b1;
        lru_en      = 1'b1;
      end
    end
  end

  // memory-side outputs
  always_comb begin
    mem_cmd_valid = 1'b0;
    mem_cmd_write = 1'b0;
    mem_cmd_line  = 1'b1;
    mem_cmd_addr  = {c_tag, c_idx, OFS_W'(0)};
    mem_wr_valid  = 1'b0;
    mem_rd_ready  = 1'b0;
    mem_wr_data   = lat_wdata_q;
    unique case (state_q)
      ST_WB_CMD: begin
        mem_cmd_valid = 1'b1;
        mem_cmd_write = 1'b1;
        mem_cmd_addr  = {way_tag[vway_q], c_idx, OFS_W'(0)};
      end
      ST_WB_DAT: begin
        mem_wr_valid = 1'b1;
        mem_wr_data  = ram_rd[vway_q];
      end
      ST_FL_CMD: mem_cmd_valid = 1'b1;
      ST_FL_DAT: mem_rd_ready  = 1'b1;
      ST_PT_CMD: begin
        mem_cmd_valid = 1'b1;
        mem_cmd_write = lat_we_q;
        mem_cmd_line  = 1'b0;
        mem_cmd_addr  = {cur_wa, BYTE_W'(0)};
      end
      ST_PT_WR: mem_wr_valid = 1'b1;
      ST_PT_RD: mem_rd_ready = 1'b1;
      default: ;
    endcase
  end

  // core-side outputs
  always_comb begin
    if (idle) core_stall = core_req && !(hit_any && !wt_write);
    else      core_stall = (state_q != ST_DONE);
    core_rdata = (state_q == ST_DONE) ? byp_q : ram_rd[hit_way];
  end

  // controller sequence
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      lat_wa_q    <= '0;
      lat_we_q    <= 1'b0;
      lat_wdata_q <= '0;
      vway_q      <= 1'b0;
      cnt_q       <= '0;
      byp_q       <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (core_req) begin
          lat_wa_q    <= core_addr[ADDR_W-1:BYTE_W];
          lat_we_q    <= core_we;
          lat_wdata_q <= core_wdata;
          vway_q      <= pick_way;
          cnt_q       <= '0;
          if (wt_write)                 state_q <= ST_PT_CMD;
          else if (hit_any)             state_q <= ST_IDLE;
          else if (!can_alloc)          state_q <= ST_PT_CMD;
          else if (way_valid[pick_way] && way_dirty[pick_way])
                                        state_q <= ST_WB_CMD;
          else                          state_q <= ST_FL_CMD;
        end
        ST_WB_CMD: if (cmd_fire) state_q <= ST_WB_DAT;
        ST_WB_DAT: if (wr_fire) begin
          cnt_q <= cnt_q + 1'b1;
          if (last_beat) state_q <= ST_FL_CMD;
        end
        ST_FL_CMD: if (cmd_fire) state_q <= ST_FL_DAT;
        ST_FL_DAT: if (rd_fire) begin
          cnt_q <= cnt_q + 1'b1;
          if (last_beat) state_q <= ST_IDLE;
        end
        ST_PT_CMD: if (cmd_fire) state_q <= lat_we_q ? ST_PT_WR : ST_PT_RD;
        ST_PT_WR:  if (wr_fire) state_q <= ST_DONE;
        ST_PT_RD:  if (rd_fire) begin
          byp_q   <= mem_rd_data;
          state_q <= ST_DONE;
        end
        default:   state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cache2w_chk.sv
module cache2w_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_cmd_valid,
  input logic              mem_cmd_ready,
  input logic              mem_cmd_write,
  input logic              mem_cmd_line,
  input logic [ADDR_W-1:0] mem_cmd_addr,
  input logic              mem_wr_valid,
  input logic              mem_wr_ready,
  input logic [DATA_W-1:0] mem_wr_data,
  input logic [1:0]        lock_way,
  input logic [1:0]        way_valid,
  input logic [1:0]        hit_w,
  input logic              tag_fill_en,
  input logic              vway_q
);
  logic [3:0] wr_owed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_owed <= '0;
    else if (mem_cmd_valid && mem_cmd_ready && mem_cmd_write)
      wr_owed <= mem_cmd_line ? 4'd8 : 4'd1;
    else if (mem_wr_valid && mem_wr_ready)
      wr_owed <= wr_owed - 4'd1;
  end

  // R12
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cmd_valid && !mem_cmd_ready |=> mem_cmd_valid && $stable(mem_cmd_addr)
      && $stable(mem_cmd_write) && $stable(mem_cmd_line));

  // R12
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_valid && !mem_wr_ready |=> mem_wr_valid && $stable(mem_wr_data));

  // R12
  wr_owed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_valid |-> wr_owed != 4'd0);

  // R6
  wb_complete_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cmd_valid |-> wr_owed == 4'd0);

  // R10
  lock_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tag_fill_en |-> !(lock_way[vway_q] && way_valid[vway_q]));

  // R4
  single_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(hit_w) <= 1);
endmodule

bind cache2w_ctrl cache2w_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .mem_cmd_valid(mem_cmd_valid), .mem_cmd_ready(mem_cmd_ready),
  .mem_cmd_write(mem_cmd_write), .mem_cmd_line(mem_cmd_line),
  .mem_cmd_addr(mem_cmd_addr), .mem_wr_valid(mem_wr_valid),
  .mem_wr_ready(mem_wr_ready), .mem_wr_data(mem_wr_data),
  .lock_way(lock_way), .way_valid(way_valid), .hit_w(hit_w),
  .tag_fill_en(tag_fill_en), .vway_q(vway_q)
);

// File: tb/sim_cache2w_ctrl.sv
module sim_cache2w_ctrl;
  timeunit 1ns;
  timeprecision 100ps;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wt_mode = 1'b0;
  logic [1:0]  lock_way = 2'b00;
  logic        core_req = 1'b0, core_we = 1'b0;
  logic [31:0] core_addr = '0;
  logic [63:0] core_wdata = '0;
  logic [63:0] core_rdata;
  logic        core_stall;
  logic        mem_cmd_valid, mem_cmd_write, mem_cmd_line;
  logic        mem_cmd_ready = 1'b0;
  logic [31:0] mem_cmd_addr;
  logic        mem_wr_valid;
  logic        mem_wr_ready = 1'b0;
  logic [63:0] mem_wr_data;
  logic        mem_rd_valid = 1'b0;
  logic        mem_rd_ready;
  logic [63:0] mem_rd_data = '0;

  always #2.5 clk = ~clk;

  cache2w_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .wt_mode(wt_mode), .lock_way(lock_way),
    .core_req(core_req), .core_we(core_we), .core_addr(core_addr),
    .core_wdata(core_wdata), .core_rdata(core_rdata), .core_stall(core_stall),
    .mem_cmd_valid(mem_cmd_valid), .mem_cmd_ready(mem_cmd_ready),
    .mem_cmd_write(mem_cmd_write), .mem_cmd_line(mem_cmd_line),
    .mem_cmd_addr(mem_cmd_addr), .mem_wr_valid(mem_wr_valid),
    .mem_wr_ready(mem_wr_ready), .mem_wr_data(mem_wr_data),
    .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready),
    .mem_rd_data(mem_rd_data)
  );

  int n_chk = 0, n_err = 0;
  logic [63:0] mem_m [int unsigned];
  logic [63:0] sh_m  [int unsigned];

  // memory-side traffic record
  int n_line_rd = 0, n_line_wr = 0, n_pt_rd = 0, n_pt_wr = 0, seq = 0;
  int wb_seq = 0, fill_seq = 0;
  logic [31:0] last_cmd_addr = '0;
  bit bp = 1'b0;
  int pend_rd = 0, pend_wr = 0;
  logic [31:0] rd_a = '0, wr_a = '0;

  function automatic logic [63:0] init_val(int unsigned w);
    return {w ^ 32'h5a5a_0000, ~w};
  endfunction
  function automatic logic [63:0] mem_get(logic [31:0] a);
    int unsigned w = a >> 3;
    return mem_m.exists(w) ? mem_m[w] : init_val(w);
  endfunction
  function automatic logic [63:0] sh_get(logic [31:0] a);
    int unsigned w = a >> 3;
    return sh_m.exists(w) ? sh_m[w] : init_val(w);
  endfunction
  function automatic logic [31:0] mk(int t, int s, int w);
    return 32'((t << 10) | (s << 6) | (w << 3));
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory responder
  initial begin
    forever begin
      @(negedge clk);
      mem_cmd_ready = bp ? 1'($urandom % 2) : 1'b1;
      mem_wr_ready  = bp ? 1'($urandom % 2) : 1'b1;
      if (pend_rd > 0 && (!bp || ($urandom % 2) == 0)) begin
        mem_rd_valid = 1'b1;
        mem_rd_data  = mem_get(rd_a);
      end else begin
        mem_rd_valid = 1'b0;
      end
      #1;
      if (mem_rd_valid && mem_rd_ready) begin pend_rd--; rd_a += 8; end
      if (mem_wr_valid && mem_wr_ready && pend_wr > 0) begin
        mem_m[wr_a >> 3] = mem_wr_data;
        pend_wr--; wr_a += 8;
      end
      if (mem_cmd_valid && mem_cmd_ready) begin
        seq++;
        last_cmd_addr = mem_cmd_addr;
        if (mem_cmd_write) begin
          pend_wr = mem_cmd_line ? 8 : 1; wr_a = mem_cmd_addr;
          if (mem_cmd_line) begin n_line_wr++; wb_seq = seq; end else n_pt_wr++;
        end else begin
          pend_rd = mem_cmd_line ? 8 : 1; rd_a = mem_cmd_addr;
          if (mem_cmd_line) begin n_line_rd++; fill_seq = seq; end else n_pt_rd++;
        end
      end
    end
  end

  task automatic acc(input logic we, input logic [31:0] a, input logic [63:0] d,
                     output logic [63:0] q, output int cyc);
    @(negedge clk);
    core_req = 1'b1; core_we = we; core_addr = a; core_wdata = d;
    cyc = 0;
    #1;
    while (core_stall && cyc < 3000) begin
      @(negedge clk); #1; cyc++;
    end
    q = core_rdata;
    if (we) sh_m[a >> 3] = d;
    @(posedge clk); #1;
    core_req = 1'b0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    summary();
  end

  initial begin
    logic [63:0] q;
    int cyc, l0, w0, p0, pr0, s0;
    logic [31:0] a;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(!core_stall && !mem_cmd_valid, "R1 idle after reset", {core_stall, mem_cmd_valid}, 0);

    // R1 R4: first read misses and fills
    a = mk(1, 2, 3);
    l0 = n_line_rd;
    acc(0, a, 0, q, cyc);
    chk(cyc > 0, "R1 first access misses", cyc, 1);
    chk(q == sh_get(a), "R4 fill data", q, sh_get(a));
    chk(n_line_rd == l0 + 1 && last_cmd_addr == mk(1, 2, 0), "R4 line-aligned fill", last_cmd_addr, mk(1, 2, 0));
    // R3 hit
    acc(0, mk(1, 2, 5), 0, q, cyc);
    chk(cyc == 0 && q == sh_get(mk(1, 2, 5)), "R3 read hit", q, sh_get(mk(1, 2, 5)));
    // R2 byte bits ignored
    acc(0, a + 5, 0, q, cyc);
    chk(cyc == 0 && q == sh_get(a), "R2 byte field ignored", q, sh_get(a));
    // R5 write-back hit
    s0 = seq;
    acc(1, a, 64'hdead_beef_0123_4567, q, cyc);
    chk(cyc == 0 && seq == s0, "R5 write hit no traffic", seq, s0);
    acc(0, a, 0, q, cyc);
    chk(q == 64'hdead_beef_0123_4567 && mem_get(a) != q, "R5 cached copy only", mem_get(a), init_val(a >> 3));
    // fill way1 with B, then D evicts dirty A
    acc(0, mk(2, 2, 0), 0, q, cyc);
    w0 = n_line_wr;
    acc(0, mk(4, 2, 1), 0, q, cyc);
    chk(n_line_wr == w0 + 1 && wb_seq < fill_seq, "R6 write-back before fill", wb_seq, fill_seq);
    chk(mem_get(a) == 64'hdead_beef_0123_4567, "R6 memory holds dirty data", mem_get(a), 64'hdead_beef_0123_4567);
    // R8 LRU: way0=D way1=B, touch B, C evicts D
    acc(0, mk(2, 2, 0), 0, q, cyc);
    acc(0, mk(3, 2, 0), 0, q, cyc);
    acc(0, mk(2, 2, 0), 0, q, cyc);
    chk(cyc == 0, "R8 recent line kept", cyc, 0);
    acc(0, mk(4, 2, 1), 0, q, cyc);
    chk(cyc > 0 && q == sh_get(mk(4, 2, 1)), "R8 least recent replaced", cyc, 1);
    // R7 write-through
    wt_mode = 1'b1;
    p0 = n_pt_wr;
    acc(1, mk(2, 2, 0), 64'h1111_2222_3333_4444, q, cyc);
    chk(n_pt_wr == p0 + 1 && mem_get(mk(2, 2, 0)) == 64'h1111_2222_3333_4444, "R7 write-through hit", mem_get(mk(2, 2, 0)), 64'h1111_2222_3333_4444);
    acc(0, mk(2, 2, 0), 0, q, cyc);
    chk(cyc == 0 && q == 64'h1111_2222_3333_4444, "R7 hit copy updated", q, 64'h1111_2222_3333_4444);
    l0 = n_line_rd;
    acc(1, mk(5, 2, 0), 64'h5555_6666_7777_8888, q, cyc);
    chk(n_line_rd == l0 && mem_get(mk(5, 2, 0)) == 64'h5555_6666_7777_8888, "R7 write miss no allocate", n_line_rd, l0);
    acc(0, mk(5, 2, 0), 0, q, cyc);
    chk(n_line_rd == l0 + 1 && q == 64'h5555_6666_7777_8888, "R7 later read misses", n_line_rd, l0 + 1);
    wt_mode = 1'b0;
    // R9 locked invalid ways still fill
    lock_way = 2'b11;
    l0 = n_line_rd;
    acc(0, mk(1, 5, 0), 0, q, cyc);
    acc(0, mk(2, 5, 0), 0, q, cyc);
    chk(n_line_rd == l0 + 2, "R9 locked invalid ways fill", n_line_rd, l0 + 2);
    acc(0, mk(1, 5, 0), 0, q, cyc);
    chk(cyc == 0, "R9 filled line hits", cyc, 0);
    // R11 pass-through
    pr0 = n_pt_rd; l0 = n_line_rd;
    acc(0, mk(3, 5, 2), 0, q, cyc);
    chk(n_pt_rd == pr0 + 1 && n_line_rd == l0 && q == sh_get(mk(3, 5, 2)), "R11 pass-through read", q, sh_get(mk(3, 5, 2)));
    p0 = n_pt_wr;
    acc(1, mk(3, 5, 2), 64'h9999_aaaa_bbbb_cccc, q, cyc);
    chk(n_pt_wr == p0 + 1 && mem_get(mk(3, 5, 2)) == 64'h9999_aaaa_bbbb_cccc, "R11 pass-through write", mem_get(mk(3, 5, 2)), 64'h9999_aaaa_bbbb_cccc);
    acc(0, mk(1, 5, 0), 0, q, cyc);
    chk(cyc == 0, "R11 way0 line unchanged", cyc, 0);
    acc(0, mk(2, 5, 0), 0, q, cyc);
    chk(cyc == 0, "R11 way1 line unchanged", cyc, 0);
    acc(0, mk(3, 5, 2), 0, q, cyc);
    chk(q == 64'h9999_aaaa_bbbb_cccc, "R11 pass-through read back", q, 64'h9999_aaaa_bbbb_cccc);
    // R10 way0 locked, LRU points at way0
    lock_way = 2'b01;
    acc(0, mk(2, 5, 0), 0, q, cyc);
    acc(0, mk(3, 5, 2), 0, q, cyc);
    acc(0, mk(1, 5, 0), 0, q, cyc);
    chk(cyc == 0, "R10 locked line kept", cyc, 0);
    acc(0, mk(2, 5, 0), 0, q, cyc);
    chk(cyc > 0, "R10 unlocked way replaced", cyc, 1);
    lock_way = 2'b00;

    // R12 random traffic with back-pressure
    bp = 1'b1;
    for (int i = 0; i < 500; i++) begin
      logic we;
      if (i % 25 == 0) lock_way = 2'($urandom % 4);
      wt_mode = (($urandom % 4) == 0);
      we = (($urandom % 3) == 0);
      a = mk($urandom % 6, $urandom % 4, $urandom % 8);
      if (we) acc(1, a, {$urandom, $urandom}, q, cyc);
      else begin
        logic [63:0] e;
        e = sh_get(a);
        acc(0, a, 0, q, cyc);
        chk(q == e && cyc < 3000, "R12 random read data", q, e);
      end
    end
    summary();
  end
endmodule